// File: doc/BRIEF.md
# Three-Axis Workgroup Dispatch Sequencer

This block walks through the workgroups of a three-dimensional compute grid, one per advance request. A start command captures the grid extent and the workgroup extent on each axis. The block then works out how many workgroups each axis holds (rounding up, so a partial last workgroup counts) and the product of the three. Each accepted advance moves to the next workgroup in X-fastest order and bumps a flat workgroup number. When the last workgroup has been handed out, a sticky flag signals that dispatch is finished.

An axis wraps when the next index multiplied by that axis's workgroup extent reaches or passes the grid extent. It does not wrap by comparing against a precomputed count. A separate counter tallies completion pulses from downstream. A zero workgroup extent in a start command is rejected with an error flag. The rounded-up division is done either by a serial restoring divider or, when a parameter selects it, by a single-cycle shift that assumes power-of-two workgroup extents.

Top module: `wg_grid_sequencer`

## Requirements
- R1: After reset, every index, the flat number, the three per-axis counts, the total, and the completion tally are zero, and the finished, counts-ready and error flags are low.
- R2: A start pulse clears the indices, the flat number, the finished flag and the completion tally on the next edge, and drops counts-ready. A start pulse wins over an advance or a completion pulse in the same cycle.
- R3: Once counts-ready rises, each per-axis count equals the grid extent divided by the workgroup extent, rounded up, and the total equals the product of the three counts.
- R4: An accepted advance increments the flat number by one on the next edge. If X does not wrap, it also increments the X index by one.
- R5: On an accepted advance where (X index + 1) × X extent reaches or exceeds the X grid size, X returns to 0 and Y is stepped.
- R6: When Y is stepped and (Y index + 1) × Y extent reaches or exceeds the Y grid size, Y returns to 0 and Z increments.
- R7: When Z increments and the new Z index × Z extent reaches or exceeds the Z grid size, the finished flag is set. The indices then read X=0, Y=0, Z=Z count, and the flat number equals the total.
- R8: An advance is ignored while counts-ready is low or the finished flag is set. The indices and the flat number do not change.
- R9: Each cycle with the completion pulse high (and no start) adds one to the completion tally, whether or not dispatch is finished.
- R10: A start with any workgroup extent of zero raises the error flag, and counts-ready stays low so every advance is ignored. The next start with all extents nonzero clears the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture sizes and restart the walk |
| grid_x_i | input | DIM_W | Grid extent, X |
| grid_y_i | input | DIM_W | Grid extent, Y |
| grid_z_i | input | DIM_W | Grid extent, Z |
| wsz_x_i | input | DIM_W | Workgroup extent, X |
| wsz_y_i | input | DIM_W | Workgroup extent, Y |
| wsz_z_i | input | DIM_W | Workgroup extent, Z |
| advance_i | input | 1 | Step to the next workgroup |
| wg_done_i | input | 1 | One workgroup has completed |
| idx_x_o | output | DIM_W | Current X workgroup index |
| idx_y_o | output | DIM_W | Current Y workgroup index |
| idx_z_o | output | DIM_W | Current Z workgroup index |
| global_id_o | output | 3*DIM_W | Flat workgroup number |
| count_x_o | output | DIM_W | Workgroups along X |
| count_y_o | output | DIM_W | Workgroups along Y |
| count_z_o | output | DIM_W | Workgroups along Z |
| count_total_o | output | 3*DIM_W | Product of the three counts |
| done_count_o | output | 3*DIM_W | Completion tally |
| dispatch_done_o | output | 1 | All workgroups handed out |
| counts_valid_o | output | 1 | Counts computed, advances accepted |
| err_o | output | 1 | Last start had a zero workgroup extent |

## Verification
The walk is swept over every grid of 1–5 × 1–3 × 1–3 with workgroup extents of 1–3 × 1–2 × 1–2. Exact multiples and partial last workgroups therefore appear on every axis, as do single-workgroup axes where every advance wraps. At every step, the indices are compared with a nested X-inner loop over the rounded-up counts, and the flat number with the loop position. This separates a wrong wrap compare (off by one at the boundary) from a wrong carry chain or a wrong stop point. Separate runs cover an advance during division, an advance after finish, a zero extent, and the completion tally across a restart.

// File: rtl/wgs_pkg.sv
package wgs_pkg;
  typedef enum logic {DIV_IDLE = 1'b0, DIV_RUN = 1'b1} div_state_e;
  localparam int NUM_AXES = 3;
endpackage

// File: rtl/wgs_ceil_div.sv
module wgs_ceil_div
  import wgs_pkg::*;
#(
  parameter int W    = 16,
  parameter bit POW2 = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);
  localparam int CW = $clog2(W + 2);

  // rounded-up dividend: num + den - 1 needs one extra bit
  logic [W:0] biased;
  assign biased = {1'b0, num} + {1'b0, den} - {{W{1'b0}}, 1'b1};

  generate
    if (POW2) begin : g_shift
      localparam int LW = $clog2(W) + 1;
      logic [LW-1:0] lg;
      always_comb begin
        lg = '0;
        for (int i = 0; i < W; i++) begin
          if (den[i]) lg = LW'(i);
        end
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          quo  <= '0;
          done <= 1'b0;
        end else if (go) begin
          quo  <= W'(biased >> lg);
          done <= 1'b1;
        end
      end
    end else begin : g_serial
      div_state_e    st;
      logic [W:0]    rem, dvd, q;
      logic [W-1:0]  den_q;
      logic [CW-1:0] cnt;
      logic [W:0]    trial;
      assign trial = {rem[W-1:0], dvd[W]};
      assign quo   = q[W-1:0];
      always_ff @(posedge clk) begin
        if (rst) begin
          st    <= DIV_IDLE;
          rem   <= '0;
          dvd   <= '0;
          q     <= '0;
          den_q <= '0;
          cnt   <= '0;
          done  <= 1'b0;
        end else if (go) begin
          st    <= DIV_RUN;
          rem   <= '0;
          dvd   <= biased;
          q     <= '0;
          den_q <= den;
          cnt   <= CW'(W + 1);
          done  <= 1'b0;
        end else if (st == DIV_RUN) begin
          dvd <= {dvd[W-1:0], 1'b0};
          if (trial >= {1'b0, den_q}) begin
            rem <= trial - {1'b0, den_q};
            q   <= {q[W-1:0], 1'b1};
          end else begin
            rem <= trial;
            q   <= {q[W-1:0], 1'b0};
          end
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            st   <= DIV_IDLE;
            done <= 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wgs_axis_step.sv
module wgs_axis_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] idx,
  input  logic [W-1:0] wsz,
  input  logic [W-1:0] grid,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  logic [2*W-1:0] reach;
  assign nxt   = idx + 1'b1;
  assign reach = (2*W)'(nxt) * (2*W)'(wsz);
  assign wrap  = reach >= (2*W)'(grid);
endmodule

// File: rtl/wg_grid_sequencer.sv
module wg_grid_sequencer
  import wgs_pkg::*;
#(
  parameter int DIM_W      = 16,
  parameter bit POW2_SIZES = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [DIM_W-1:0]     grid_x_i,
  input  logic [DIM_W-1:0]     grid_y_i,
  input  logic [DIM_W-1:0]     grid_z_i,
  input  logic [DIM_W-1:0]     wsz_x_i,
  input  logic [DIM_W-1:0]     wsz_y_i,
  input  logic [DIM_W-1:0]     wsz_z_i,
  input  logic                 advance_i,
  input  logic                 wg_done_i,
  output logic [DIM_W-1:0]     idx_x_o,
  output logic [DIM_W-1:0]     idx_y_o,
  output logic [DIM_W-1:0]     idx_z_o,
  output logic [3*DIM_W-1:0]   global_id_o,
  output logic [DIM_W-1:0]     count_x_o,
  output logic [DIM_W-1:0]     count_y_o,
  output logic [DIM_W-1:0]     count_z_o,
  output logic [3*DIM_W-1:0]   count_total_o,
  output logic [3*DIM_W-1:0]   done_count_o,
  output logic                 dispatch_done_o,
  output logic                 counts_valid_o,
  output logic                 err_o
);
  localparam int TOT_W = 3 * DIM_W;

  logic [NUM_AXES-1:0][DIM_W-1:0] grid_in, wsz_in, grid_q, wsz_q;
  logic [NUM_AXES-1:0][DIM_W-1:0] idx_q, nxt_idx, cnt_w;
  logic [NUM_AXES-1:0]            wrap, div_done;
  logic [TOT_W-1:0]               gid_q, total_q, tally_q, product;
  logic                           fin_q, valid_q, err_q;
  logic                           zero_size, launch, step_ok;

  assign grid_in   = {grid_z_i, grid_y_i, grid_x_i};
  assign wsz_in    = {wsz_z_i, wsz_y_i, wsz_x_i};
  assign zero_size = (wsz_x_i == '0) | (wsz_y_i == '0) | (wsz_z_i == '0);
  assign launch    = start_i & ~zero_size;
  assign step_ok   = advance_i & valid_q & ~fin_q & ~start_i;
  assign product   = TOT_W'(cnt_w[0]) * TOT_W'(cnt_w[1]) * TOT_W'(cnt_w[2]);

  generate
    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      wgs_ceil_div #(.W(DIM_W), .POW2(POW2_SIZES)) u_div (
        .clk (clk),
        .rst (rst),
        .go  (launch),
        .num (grid_in[a]),
        .den (wsz_in[a]),
        .quo (cnt_w[a]),
        .done(div_done[a])
      );
      wgs_axis_step #(.W(DIM_W)) u_step (
        .idx (idx_q[a]),
        .wsz (wsz_q[a]),
        .grid(grid_q[a]),
        .nxt (nxt_idx[a]),
        .wrap(wrap[a])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      grid_q  <= '0;
      wsz_q   <= '0;
      idx_q   <= '0;
      gid_q   <= '0;
      total_q <= '0;
      tally_q <= '0;
      fin_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (start_i) begin
      grid_q  <= grid_in;
      wsz_q   <= wsz_in;
      idx_q   <= '0;
      gid_q   <= '0;
      total_q <= '0;
      tally_q <= '0;
      fin_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= zero_size;
    end else begin
      valid_q <= (&div_done) & ~err_q;
      if ((&div_done) & ~err_q) total_q <= product;
      if (wg_done_i) tally_q <= tally_q + 1'b1;
      if (step_ok) begin
        gid_q <= gid_q + 1'b1;
        if (!wrap[0]) begin
          idx_q[0] <= nxt_idx[0];
        end else begin
          idx_q[0] <= '0;
          if (!wrap[1]) begin
            idx_q[1] <= nxt_idx[1];
          end else begin
            idx_q[1] <= '0;
            idx_q[2] <= nxt_idx[2];
            if (wrap[2]) fin_q <= 1'b1;
          end
        end
      end
    end
  end

  assign idx_x_o         = idx_q[0];
  assign idx_y_o         = idx_q[1];
  assign idx_z_o         = idx_q[2];
  assign global_id_o     = gid_q;
  assign count_x_o       = rst ? '0 : cnt_w[0];
  assign count_y_o       = rst ? '0 : cnt_w[1];
  assign count_z_o       = rst ? '0 : cnt_w[2];
  assign count_total_o   = total_q;
  assign done_count_o    = tally_q;
  assign dispatch_done_o = fin_q;
  assign counts_valid_o  = valid_q;
  assign err_o           = err_q;
endmodule

// File: rtl/wgs_checker.sv
module wgs_checker #(
  parameter int DIM_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               advance_i,
  input logic               wg_done_i,
  input logic [DIM_W-1:0]   idx_x_o,
  input logic [DIM_W-1:0]   count_x_o,
  input logic [3*DIM_W-1:0] global_id_o,
  input logic [3*DIM_W-1:0] done_count_o,
  input logic               dispatch_done_o,
  input logic               counts_valid_o,
  input logic               err_o
);
  localparam int TOT_W = 3 * DIM_W;

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (global_id_o == '0) && !dispatch_done_o && !counts_valid_o);

  // R4
  gid_step_chk: assert property (@(posedge clk) disable iff (rst)
    (counts_valid_o && !dispatch_done_o && advance_i && !start_i)
      |=> global_id_o == $past(global_id_o) + TOT_W'(1));

  // R5
  x_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (counts_valid_o && count_x_o != '0) |-> idx_x_o < count_x_o);

  // R7
  fin_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (dispatch_done_o && !start_i) |=> dispatch_done_o);

  // R8
  no_step_after_fin_chk: assert property (@(posedge clk) disable iff (rst)
    (dispatch_done_o && !start_i) |=> $stable(global_id_o));

  // R9
  tally_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wg_done_i && !start_i) |=> done_count_o == $past(done_count_o) + TOT_W'(1));

  // R10
  err_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !counts_valid_o);
endmodule

bind wg_grid_sequencer wgs_checker #(.DIM_W(DIM_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .advance_i      (advance_i),
  .wg_done_i      (wg_done_i),
  .idx_x_o        (idx_x_o),
  .count_x_o      (count_x_o),
  .global_id_o    (global_id_o),
  .done_count_o   (done_count_o),
  .dispatch_done_o(dispatch_done_o),
  .counts_valid_o (counts_valid_o),
  .err_o          (err_o)
);

// File: tb/sim_wg_grid_sequencer.sv
module sim_wg_grid_sequencer;
  localparam int DIM_W = 8;
  localparam int TOT_W = 3 * DIM_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, advance_i = 1'b0, wg_done_i = 1'b0;
  logic [DIM_W-1:0] grid_x_i = '0, grid_y_i = '0, grid_z_i = '0;
  logic [DIM_W-1:0] wsz_x_i = '0, wsz_y_i = '0, wsz_z_i = '0;
  logic [DIM_W-1:0] idx_x_o, idx_y_o, idx_z_o, count_x_o, count_y_o, count_z_o;
  logic [TOT_W-1:0] global_id_o, count_total_o, done_count_o;
  logic dispatch_done_o, counts_valid_o, err_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wg_grid_sequencer #(.DIM_W(DIM_W), .POW2_SIZES(1'b0)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i),
    .grid_x_i(grid_x_i), .grid_y_i(grid_y_i), .grid_z_i(grid_z_i),
    .wsz_x_i(wsz_x_i), .wsz_y_i(wsz_y_i), .wsz_z_i(wsz_z_i),
    .advance_i(advance_i), .wg_done_i(wg_done_i),
    .idx_x_o(idx_x_o), .idx_y_o(idx_y_o), .idx_z_o(idx_z_o),
    .global_id_o(global_id_o),
    .count_x_o(count_x_o), .count_y_o(count_y_o), .count_z_o(count_z_o),
    .count_total_o(count_total_o), .done_count_o(done_count_o),
    .dispatch_done_o(dispatch_done_o), .counts_valid_o(counts_valid_o),
    .err_o(err_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int gx, input int gy, input int gz,
                          input int wx, input int wy, input int wz);
    @(negedge clk);
    grid_x_i = DIM_W'(gx); grid_y_i = DIM_W'(gy); grid_z_i = DIM_W'(gz);
    wsz_x_i = DIM_W'(wx); wsz_y_i = DIM_W'(wy); wsz_z_i = DIM_W'(wz);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_advance();
    advance_i = 1'b1;
    @(negedge clk);
    advance_i = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 64 && !counts_valid_o; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 idx_x", idx_x_o, 0);
    check("R1 idx_y", idx_y_o, 0);
    check("R1 idx_z", idx_z_o, 0);
    check("R1 gid", global_id_o, 0);
    check("R1 count_x", count_x_o, 0);
    check("R1 total", count_total_o, 0);
    check("R1 tally", done_count_o, 0);
    check("R1 flags", {dispatch_done_o, counts_valid_o, err_o}, 0);

    // R8: advance during division is ignored
    do_start(4, 1, 1, 1, 1, 1);
    check("R2 valid low after start", counts_valid_o, 0);
    pulse_advance();
    check("R8 gid during division", global_id_o, 0);
    check("R8 idx_x during division", idx_x_o, 0);
    wait_valid();
    check("R3 valid rises", counts_valid_o, 1);

    // R9 completion tally, R2 clears it on start
    wg_done_i = 1'b1;
    repeat (3) @(negedge clk);
    wg_done_i = 1'b0;
    check("R9 tally", done_count_o, 3);
    do_start(2, 1, 1, 1, 1, 1);
    check("R2 tally cleared", done_count_o, 0);
    wait_valid();

    // R10 zero extent
    do_start(4, 4, 4, 2, 0, 1);
    check("R10 err set", err_o, 1);
    repeat (30) @(negedge clk);
    check("R10 valid stays low", counts_valid_o, 0);
    pulse_advance();
    check("R10 advance ignored gid", global_id_o, 0);
    check("R10 advance ignored idx", idx_x_o, 0);
    do_start(3, 1, 1, 1, 1, 1);
    check("R10 err cleared", err_o, 0);
    wait_valid();
    check("R10 valid after good start", counts_valid_o, 1);

    // sweep
    for (int gx = 1; gx <= 5; gx++)
    for (int wx = 1; wx <= 3; wx++)
    for (int gy = 1; gy <= 3; gy++)
    for (int wy = 1; wy <= 2; wy++)
    for (int gz = 1; gz <= 3; gz++)
    for (int wz = 1; wz <= 2; wz++) begin
      int cx, cy, cz, lin;
      cx = (gx + wx - 1) / wx;
      cy = (gy + wy - 1) / wy;
      cz = (gz + wz - 1) / wz;
      do_start(gx, gy, gz, wx, wy, wz);
      check("R2 fin cleared", dispatch_done_o, 0);
      wait_valid();
      check("R3 count_x", count_x_o, cx);
      check("R3 count_y", count_y_o, cy);
      check("R3 count_z", count_z_o, cz);
      check("R3 total", count_total_o, cx * cy * cz);
      lin = 0;
      for (int z = 0; z < cz; z++)
        for (int y = 0; y < cy; y++)
          for (int x = 0; x < cx; x++) begin
            check("R5 idx_x", idx_x_o, x);
            check("R6 idx_y", idx_y_o, y);
            check("R7 idx_z", idx_z_o, z);
            check("R4 gid", global_id_o, lin);
            check("R7 not finished early", dispatch_done_o, 0);
            pulse_advance();
            lin++;
          end
      check("R7 finished", dispatch_done_o, 1);
      check("R7 gid equals total", global_id_o, cx * cy * cz);
      check("R7 final idx_x", idx_x_o, 0);
      check("R7 final idx_y", idx_y_o, 0);
      check("R7 final idx_z", idx_z_o, cz);
      pulse_advance();
      check("R8 gid after finish", global_id_o, cx * cy * cz);
      check("R8 idx_z after finish", idx_z_o, cz);
    end

    // R9 tally keeps counting after finish
    wg_done_i = 1'b1;
    @(negedge clk);
    wg_done_i = 1'b0;
    check("R9 tally after finish", done_count_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule